// File: doc/BRIEF.md
# Multicycle Stored-Program Processor Core

This block is a small processor that runs a sixteen-opcode register-machine program from one unified word memory. Data words sit at the low addresses and the instructions follow them. Execution begins at the address given on `start_pc`, which is normally the length of the data segment. The machine has four general registers, a register that always reads zero, a program counter, a signed status word and a return-address register. A compare puts the full signed difference into the status word. There are no condition flags; the conditional branches test the sign of that word.

Every instruction goes through a fixed sequence of phases: fetch at the program counter, decode, operand read, counter increment, then execute. A load adds one write-back phase, because the memory returns read data one cycle after it is given an address. A halt instruction freezes the machine. The program counter, status word, return address and general registers stay visible on the debug outputs for the bench or the surrounding logic to inspect.

Top module: `spc_core`

## Requirements
- R1: While reset is asserted, the general registers, status word, return address and program counter are all 0 and `halted` is low. On the first clock edge after reset is released, the program counter takes the value on `start_pc`.
- R2: An instruction word holds the opcode in bits [31:28], field A in [27:25], field B in [24:22], field C in [21:19] and a signed 16-bit immediate in [15:0]. The opcodes are: load 0, store 1, move 2, halt 3, add 4, subtract 5, multiply 6, divide 7, compare 8, load-immediate 9, call 10, return 11, jump 12, branch-if-negative 13, branch-if-zero 14, branch-if-positive 15.
- R3: Add (4), subtract (5) and multiply (6) write B+C, B−C and the low 32 bits of B×C into register A. All values are 32-bit two's complement and wrap on overflow.
- R4: Divide (7) writes the signed quotient B/C into register A, rounded toward zero. A zero divisor writes 0.
- R5: Compare (8) writes the signed difference A−B into the status word and leaves every general register unchanged. No other opcode changes the status word.
- R6: Load (0) writes memory[B + imm] into register A. Store (1) writes register A to memory[B + imm] with a write-enable pulse of exactly one cycle.
- R7: Load-immediate (9) writes the sign-extended immediate into register A. Move (2) copies register B into register A.
- R8: Register codes 0 to 3 select R0 to R3. Code 4 is the zero register and reads 0. Codes 5 to 7 also read 0. A write to any code from 4 to 7 is discarded.
- R9: Jump (12) always branches. Branch-if-negative (13), branch-if-zero (14) and branch-if-positive (15) branch when the status word is below, equal to or above zero. A branch sets the counter to the already-incremented PC plus the immediate.
- R10: Call (10) saves the incremented PC into the return-address register and then branches by the immediate. Return (11) loads the PC from the return-address register. No other opcode changes the return-address register.
- R11: Halt (3) raises `halted`, which stays high until reset. After the halt the PC holds the address just past the halt instruction, and no further state changes or memory writes occur.
- R12: After reset is released, one start-up cycle passes. Each instruction then takes five cycles, except a load, which takes six.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_pc | input | AW | Address of the first instruction, taken after reset |
| mem_addr | output | AW | Word address to the synchronous memory |
| mem_rdata | input | 32 | Read data, valid one cycle after the address |
| mem_wdata | output | 32 | Write data for a store |
| mem_we | output | 1 | Write enable for a store |
| halted | output | 1 | High once a halt instruction has executed |
| dbg_pc | output | AW | Program counter |
| dbg_status | output | 32 | Signed status word |
| dbg_ret | output | AW | Return-address register |
| dbg_gpr | output | 4*32 | General registers, R0 in the lowest 32 bits |

## Verification
Results appear on the debug outputs only after the halt phase. That point is one start-up cycle plus five cycles per instruction and six per load after reset is released. The bench counts clock edges from release and reads all register values on the falling edge after `halted` rises. The count itself is checked against that formula. The bench also samples the program counter on the falling edge after the first rising edge, which confirms that the start address was taken. Stores are checked in the bench memory once the run has halted.

// File: rtl/spc_pkg.sv
package spc_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned IMM_W  = 16;
  localparam int unsigned SEL_W  = 3;

  typedef enum logic [3:0] {
    OP_LOAD  = 4'd0,  OP_STORE = 4'd1,  OP_MOVE = 4'd2,  OP_HALT = 4'd3,
    OP_ADD   = 4'd4,  OP_SUB   = 4'd5,  OP_MUL  = 4'd6,  OP_DIV  = 4'd7,
    OP_CMP   = 4'd8,  OP_LDI   = 4'd9,  OP_CALL = 4'd10, OP_RET  = 4'd11,
    OP_JMP   = 4'd12, OP_BLT   = 4'd13, OP_BEQ  = 4'd14, OP_BGT  = 4'd15
  } opcode_e;

  typedef enum logic [2:0] {
    PH_BOOT, PH_FETCH, PH_DECODE, PH_OPREAD, PH_PCINC, PH_EXEC, PH_LDWB, PH_HALT
  } phase_e;

  // decoded instruction; bits [18:16] of the word are reserved
  typedef struct packed {
    opcode_e            op;
    logic [SEL_W-1:0]   fa;
    logic [SEL_W-1:0]   fb;
    logic [SEL_W-1:0]   fc;
    logic [IMM_W-1:0]   imm;
  } instr_t;

endpackage

// File: rtl/spc_alu.sv
module spc_alu
  import spc_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  opcode_e        op,
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic [W-1:0]   res
);

  always_comb begin
    unique case (op)
      OP_ADD:  res = x + y;
      OP_MUL:  res = x * y;
      OP_DIV: begin
        if (y == '0)
          res = '0;
        else if (y == '1)
          res = '0 - x;                    // avoids the most-negative overflow case
        else
          res = W'($signed(x) / $signed(y));
      end
      default: res = x - y;                // subtract and compare
    endcase
  end

endmodule

// File: rtl/spc_regfile.sv
module spc_regfile
  import spc_pkg::*;
#(
  parameter int unsigned W   = WORD_W,
  parameter int unsigned NUM = 4,
  parameter int unsigned SW  = SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SW-1:0]    sel_a,
  input  logic [SW-1:0]    sel_b,
  input  logic [SW-1:0]    sel_c,
  output logic [W-1:0]     dat_a,
  output logic [W-1:0]     dat_b,
  output logic [W-1:0]     dat_c,
  input  logic             wr_en,
  input  logic [SW-1:0]    wr_sel,
  input  logic [W-1:0]     wr_data,
  output logic [NUM*W-1:0] all_regs
);

  localparam int unsigned IW = (NUM > 1) ? $clog2(NUM) : 1;

  logic [W-1:0] regs [NUM];

  // codes at or above NUM (zero register and undefined codes) have no storage
  for (genvar g = 0; g < NUM; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (wr_en && (wr_sel == SW'(g)))
        regs[g] <= wr_data;
    end
    assign all_regs[g*W +: W] = regs[g];
  end

  assign dat_a = (sel_a < SW'(NUM)) ? regs[sel_a[IW-1:0]] : '0;
  assign dat_b = (sel_b < SW'(NUM)) ? regs[sel_b[IW-1:0]] : '0;
  assign dat_c = (sel_c < SW'(NUM)) ? regs[sel_c[IW-1:0]] : '0;

endmodule

// File: rtl/spc_core.sv
module spc_core
  import spc_pkg::*;
#(
  parameter int unsigned AW      = 8,
  parameter int unsigned NUM_GPR = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [AW-1:0]             start_pc,
  output logic [AW-1:0]             mem_addr,
  input  logic [WORD_W-1:0]         mem_rdata,
  output logic [WORD_W-1:0]         mem_wdata,
  output logic                      mem_we,
  output logic                      halted,
  output logic [AW-1:0]             dbg_pc,
  output logic [WORD_W-1:0]         dbg_status,
  output logic [AW-1:0]             dbg_ret,
  output logic [NUM_GPR*WORD_W-1:0] dbg_gpr
);

  localparam int unsigned W = WORD_W;

  phase_e         phase_q, phase_d;
  logic [AW-1:0]  pc_q, pc_d, ret_q, ea, pc_rel;
  logic           pc_en, status_en, ret_en, ir_en, opr_en;
  logic [W-1:0]   status_q;
  instr_t         ir_q, ir_d;
  logic [W-1:0]   opa_q, opb_q, opc_q;
  logic [W-1:0]   rfa, rfb, rfc, alu_x, alu_y, alu_res, imm_ext, rf_wd;
  logic           rf_we, take;

  // ---------------- datapath ----------------
  assign ir_d = '{op:  opcode_e'(mem_rdata[31:28]),
                  fa:  mem_rdata[27:25],
                  fb:  mem_rdata[24:22],
                  fc:  mem_rdata[21:19],
                  imm: mem_rdata[15:0]};

  always_comb begin
    imm_ext = {{(W-IMM_W){ir_q.imm[IMM_W-1]}}, ir_q.imm};
    ea      = opb_q[AW-1:0] + imm_ext[AW-1:0];
    pc_rel  = pc_q + imm_ext[AW-1:0];
    alu_x   = (ir_q.op == OP_CMP) ? opa_q : opb_q;
    alu_y   = (ir_q.op == OP_CMP) ? opb_q : opc_q;
    unique case (ir_q.op)
      OP_JMP, OP_CALL: take = 1'b1;
      OP_BLT:          take = status_q[W-1];
      OP_BEQ:          take = (status_q == '0);
      OP_BGT:          take = !status_q[W-1] && (status_q != '0);
      default:         take = 1'b0;
    endcase
  end

  spc_alu #(.W(W)) u_alu (
    .op (ir_q.op),
    .x  (alu_x),
    .y  (alu_y),
    .res(alu_res)
  );

  spc_regfile #(.W(W), .NUM(NUM_GPR), .SW(SEL_W)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_a   (ir_q.fa),
    .sel_b   (ir_q.fb),
    .sel_c   (ir_q.fc),
    .dat_a   (rfa),
    .dat_b   (rfb),
    .dat_c   (rfc),
    .wr_en   (rf_we),
    .wr_sel  (ir_q.fa),
    .wr_data (rf_wd),
    .all_regs(dbg_gpr)
  );

  // ---------------- sequencing ----------------
  always_comb begin
    phase_d   = phase_q;
    pc_d      = pc_q;
    pc_en     = 1'b0;
    status_en = 1'b0;
    ret_en    = 1'b0;
    ir_en     = 1'b0;
    opr_en    = 1'b0;
    rf_we     = 1'b0;
    rf_wd     = alu_res;
    unique case (phase_q)
      PH_BOOT: begin
        pc_d    = start_pc;
        pc_en   = 1'b1;
        phase_d = PH_FETCH;
      end
      PH_FETCH:  phase_d = PH_DECODE;
      PH_DECODE: begin
        ir_en   = 1'b1;
        phase_d = PH_OPREAD;
      end
      PH_OPREAD: begin
        opr_en  = 1'b1;
        phase_d = PH_PCINC;
      end
      PH_PCINC: begin
        pc_d    = pc_q + AW'(1);
        pc_en   = 1'b1;
        phase_d = PH_EXEC;
      end
      PH_EXEC: begin
        phase_d = PH_FETCH;
        unique case (ir_q.op)
          OP_LOAD:  phase_d = PH_LDWB;
          OP_HALT:  phase_d = PH_HALT;
          OP_MOVE: begin
            rf_we = 1'b1;
            rf_wd = opb_q;
          end
          OP_ADD, OP_SUB, OP_MUL, OP_DIV: rf_we = 1'b1;
          OP_LDI: begin
            rf_we = 1'b1;
            rf_wd = imm_ext;
          end
          OP_CMP:   status_en = 1'b1;
          OP_RET: begin
            pc_d  = ret_q;
            pc_en = 1'b1;
          end
          default: begin
            ret_en = (ir_q.op == OP_CALL);
            pc_d   = pc_rel;
            pc_en  = take;
          end
        endcase
      end
      PH_LDWB: begin
        rf_we   = 1'b1;
        rf_wd   = mem_rdata;
        phase_d = PH_FETCH;
      end
      default: phase_d = PH_HALT;
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_BOOT;
    else        phase_q <= phase_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status_q <= '0;
    else if (status_en) status_q <= alu_res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ret_q <= '0;
    else if (ret_en) ret_q <= pc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ir_q <= '0;
    else if (ir_en) ir_q <= ir_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opa_q <= '0;
      opb_q <= '0;
      opc_q <= '0;
    end else if (opr_en) begin
      opa_q <= rfa;
      opb_q <= rfb;
      opc_q <= rfc;
    end
  end

  // ---------------- outputs ----------------
  assign mem_addr   = (phase_q == PH_EXEC) ? ea : pc_q;
  assign mem_we     = (phase_q == PH_EXEC) && (ir_q.op == OP_STORE);
  assign mem_wdata  = opa_q;
  assign halted     = (phase_q == PH_HALT);
  assign dbg_pc     = pc_q;
  assign dbg_status = status_q;
  assign dbg_ret    = ret_q;

endmodule

// File: rtl/spc_core_chk.sv
module spc_core_chk #(
  parameter int unsigned AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          halted,
  input logic          mem_we,
  input logic [AW-1:0] dbg_pc,
  input logic [31:0]   dbg_status,
  input logic [AW-1:0] dbg_ret,
  input logic [3:0]    cur_op,
  input logic          in_exec
);

  // R11: once halted, the machine stays halted and the counter is frozen
  assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(dbg_pc)));

  // R11: no memory writes while halted
  assert_halt_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we);

  // R6: a store write pulse lasts one cycle
  assert_store_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R5: the status word moves only after an executed compare
  assert_status_by_cmp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dbg_status) |-> ($past(in_exec) && ($past(cur_op) == 4'd8)));

  // R10: the return address moves only after an executed call
  assert_ret_by_call_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dbg_ret) |-> ($past(in_exec) && ($past(cur_op) == 4'd10)));

endmodule

bind spc_core spc_core_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .halted    (halted),
  .mem_we    (mem_we),
  .dbg_pc    (dbg_pc),
  .dbg_status(dbg_status),
  .dbg_ret   (dbg_ret),
  .cur_op    (ir_q.op),
  .in_exec   (phase_q == PH_EXEC)
);

// File: tb/spc_core_bench.sv
`timescale 1ns/1ps
module spc_core_bench;

  localparam int AW = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [AW-1:0]   start_pc = '0;
  logic [AW-1:0]   mem_addr;
  logic [31:0]     mem_rdata = '0;
  logic [31:0]     mem_wdata;
  logic            mem_we;
  logic            halted;
  logic [AW-1:0]   dbg_pc;
  logic [31:0]     dbg_status;
  logic [AW-1:0]   dbg_ret;
  logic [127:0]    dbg_gpr;

  logic [31:0] mem [0:255];

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  spc_core #(.AW(AW), .NUM_GPR(4)) u_spc_core (
    .clk(clk), .rst_n(rst_n), .start_pc(start_pc),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .halted(halted), .dbg_pc(dbg_pc), .dbg_status(dbg_status), .dbg_ret(dbg_ret),
    .dbg_gpr(dbg_gpr)
  );

  // stimulus vectors: opcode, operand 1, operand 2, expected result
  localparam logic [99:0] VEC [0:8] = '{
    {4'd4, 32'd7,          32'd5,          32'd12},
    {4'd5, 32'd3,          32'd10,         32'hFFFF_FFF9},
    {4'd6, 32'hFFFF_FFFA,  32'd7,          32'hFFFF_FFD6},
    {4'd6, 32'h0001_0000,  32'h0001_0000,  32'h0000_0000},
    {4'd4, 32'h7FFF_FFFF,  32'd1,          32'h8000_0000},
    {4'd7, 32'd7,          32'd2,          32'd3},
    {4'd7, 32'hFFFF_FFF9,  32'd2,          32'hFFFF_FFFD},
    {4'd7, 32'd9,          32'd0,          32'd0},
    {4'd8, 32'd3,          32'd10,         32'hFFFF_FFF9}
  };

  function automatic logic [31:0] enc(input int op, input int a, input int b, input int c, input int imm);
    return {op[3:0], a[2:0], b[2:0], c[2:0], 3'b000, imm[15:0]};
  endfunction

  function automatic logic [31:0] gpr(input int i);
    return dbg_gpr[32*i +: 32];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic hold_reset;
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = 32'd0;
    @(negedge clk);
  endtask

  task automatic run(input int spc, output int ncyc);
    start_pc = spc[AW-1:0];
    @(negedge clk);
    rst_n = 1'b1;
    ncyc = 0;
    while (!halted && ncyc < 5000) begin
      @(negedge clk);
      ncyc++;
    end
    if (!halted) chk("R11 halt reached", 32'd0, 32'd1);
  endtask

  initial begin
    #(4 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int ncyc;
    logic [3:0]  vop;
    logic [31:0] vx, vy, vexp;
    string tag;

    // ---- reset state, start address, timing, load-immediate, halt hold ----
    for (int i = 0; i < 256; i++) mem[i] = 32'd0;
    mem[5] = enc(9, 0, 0, 0, -3);   // LI R0,-3
    mem[6] = enc(3, 0, 0, 0, 0);    // HLT
    start_pc = 8'd5;
    repeat (3) @(negedge clk);
    chk("R1 halted in reset", {31'd0, halted}, 32'd0);
    chk("R1 status in reset", dbg_status, 32'd0);
    chk("R1 ret in reset", {24'd0, dbg_ret}, 32'd0);
    chk("R1 pc in reset", {24'd0, dbg_pc}, 32'd0);
    for (int i = 0; i < 4; i++) chk("R1 gpr in reset", gpr(i), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 start pc taken", {24'd0, dbg_pc}, 32'd5);
    ncyc = 1;
    while (!halted && ncyc < 100) begin
      @(negedge clk);
      ncyc++;
    end
    chk("R12 cycles for two instructions", ncyc, 32'd11);
    chk("R11 pc after halt", {24'd0, dbg_pc}, 32'd7);
    chk("R7 load-immediate sign extension", gpr(0), 32'hFFFF_FFFD);
    repeat (5) @(negedge clk);
    chk("R11 halted held", {31'd0, halted}, 32'd1);
    chk("R11 pc held", {24'd0, dbg_pc}, 32'd7);
    chk("R11 no write after halt", {31'd0, mem_we}, 32'd0);

    // ---- arithmetic and compare vectors ----
    for (int v = 0; v < 9; v++) begin
      {vop, vx, vy, vexp} = VEC[v];
      hold_reset();
      mem[0] = vx;
      mem[1] = vy;
      mem[2] = enc(0, 1, 4, 0, 0);   // LOD R1,0(zero)
      mem[3] = enc(0, 2, 4, 0, 1);   // LOD R2,1(zero)
      mem[4] = (vop == 4'd8) ? enc(8, 1, 2, 0, 0) : enc(int'(vop), 0, 1, 2, 0);
      mem[5] = enc(3, 0, 0, 0, 0);
      run(2, ncyc);
      chk("R12 cycles with two loads", ncyc, 32'd23);
      chk("R6 load value", gpr(1), vx);
      if (vop == 4'd8) begin
        chk("R5 compare status", dbg_status, vexp);
        chk("R5 compare leaves R0", gpr(0), 32'd0);
      end else begin
        tag = (vop == 4'd7) ? "R4 divide" : "R3 arithmetic";
        chk(tag, gpr(0), vexp);
        chk("R5 status untouched", dbg_status, 32'd0);
      end
    end

    // ---- remainder loop: loads, compare, branch-if-negative, jump back ----
    hold_reset();
    mem[0] = 32'd17;
    mem[1] = 32'd5;
    mem[2] = enc(0, 0, 4, 0, 0);
    mem[3] = enc(0, 1, 4, 0, 1);
    mem[4] = enc(8, 0, 1, 0, 0);
    mem[5] = enc(13, 0, 0, 0, 2);
    mem[6] = enc(5, 0, 0, 1, 0);
    mem[7] = enc(12, 0, 0, 0, -4);
    mem[8] = enc(3, 0, 0, 0, 0);
    run(2, ncyc);
    chk("R9 remainder result", gpr(0), 32'd2);
    chk("R5 final status", dbg_status, 32'hFFFF_FFFD);
    chk("R9 branch-if-negative exit pc", {24'd0, dbg_pc}, 32'd9);

    // ---- factorial: branch-if-zero, multiply, move ----
    hold_reset();
    mem[0] = 32'd5;
    mem[1] = enc(9, 0, 0, 0, 1);
    mem[2] = enc(2, 2, 0, 0, 0);
    mem[3] = enc(0, 1, 4, 0, 0);
    mem[4] = enc(8, 1, 4, 0, 0);
    mem[5] = enc(14, 0, 0, 0, 3);
    mem[6] = enc(6, 0, 0, 1, 0);
    mem[7] = enc(5, 1, 1, 2, 0);
    mem[8] = enc(12, 0, 0, 0, -5);
    mem[9] = enc(3, 0, 0, 0, 0);
    run(1, ncyc);
    chk("R9 factorial result", gpr(0), 32'd120);
    chk("R7 move copy", gpr(2), 32'd1);
    chk("R9 branch-if-zero exit pc", {24'd0, dbg_pc}, 32'd10);

    // ---- call and return ----
    hold_reset();
    mem[4] = enc(10, 0, 0, 0, 2);
    mem[5] = enc(9, 3, 0, 0, 99);
    mem[6] = enc(3, 0, 0, 0, 0);
    mem[7] = enc(9, 1, 0, 0, -3);
    mem[8] = enc(11, 0, 0, 0, 0);
    run(4, ncyc);
    chk("R10 return address", {24'd0, dbg_ret}, 32'd5);
    chk("R10 subroutine ran", gpr(1), 32'hFFFF_FFFD);
    chk("R10 returned to caller", gpr(3), 32'd99);
    chk("R10 halt pc", {24'd0, dbg_pc}, 32'd7);
    chk("R12 call sequence cycles", ncyc, 32'd26);

    // ---- store, zero register, undefined codes, untaken branches ----
    hold_reset();
    mem[8]  = enc(9, 0, 0, 0, 42);   // LI R0,42
    mem[9]  = enc(1, 0, 4, 0, 3);    // STO R0,3(zero)
    mem[10] = enc(9, 3, 0, 0, 7);    // LI R3,7
    mem[11] = enc(9, 4, 0, 0, 5);    // LI zero,5 (discarded)
    mem[12] = enc(2, 2, 4, 0, 0);    // MOV R2,zero
    mem[13] = enc(2, 3, 5, 0, 0);    // MOV R3,code5
    mem[14] = enc(8, 0, 1, 0, 0);    // CMP R0,R1
    mem[15] = enc(15, 0, 0, 0, 1);   // BGT +1 taken
    mem[16] = enc(9, 1, 0, 0, 1);    // skipped
    mem[17] = enc(13, 0, 0, 0, 1);   // BLT not taken
    mem[18] = enc(9, 1, 0, 0, 2);
    mem[19] = enc(14, 0, 0, 0, 1);   // BEQ not taken
    mem[20] = enc(3, 0, 0, 0, 0);
    run(8, ncyc);
    chk("R6 stored word", mem[3], 32'd42);
    chk("R8 zero register write discarded", gpr(2), 32'd0);
    chk("R8 undefined code reads zero", gpr(3), 32'd0);
    chk("R9 positive taken, others not", gpr(1), 32'd2);
    chk("R5 positive status", dbg_status, 32'd42);
    chk("R10 ret untouched", {24'd0, dbg_ret}, 32'd0);
    chk("R9 final pc", {24'd0, dbg_pc}, 32'd21);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule